// File: doc/BRIEF.md
# Banked Register Address Pointer

This block holds the register-address pointer of a 22-register file. The file is built from 11 pairs of registers, and each pair has one register for port A and one for port B. The block turns the pointer into a register selection: a pair number, a port select and a valid flag. It also raises a flag when the pointer lands on the single configuration register that the two maps share. A serial front end loads the pointer with a register-address byte. The front end then pulses an advance strobe after each completed data byte.

A split-map bit chooses between two address maps. In the interleaved map the two registers of a pair sit at neighbouring addresses, A at the even one. In the split map all A registers come first from address 0, and all B registers start at a fixed base. A byte-mode bit chooses what an advance does:
- Sequential mode steps the pointer through the active map and wraps to zero after the last register.
- Byte mode holds the pointer in the split map.
- Byte mode toggles between the A and B registers of the current pair in the interleaved map.

A load in the same cycle as an advance wins over the advance.

Top module: `bank_addr_ptr`

## Requirements
- R1: While reset is asserted, and after it is released, the pointer is 00h, which decodes as pair 0, port A, valid, configuration flag low.
- R2: With `bank_split`=0, an address a ≤ 15h decodes as valid with pair a>>1 and port select a[0] (0 = port A, 1 = port B); any higher address is invalid.
- R3: With `bank_split`=1, addresses 00h–0Ah decode as pair a, port A. Addresses 10h–1Ah decode as pair a−10h, port B. Every other address is invalid, and an invalid address drives pair 0 and port select 0.
- R4: The configuration register is pair 5. With `bank_split`=0 it is reached at 0Ah and 0Bh, and with `bank_split`=1 at 05h and 15h. At each of these addresses `cfg_hit`=1 and `reg_port_b`=0.
- R5: When `addr_load`=1 at a clock edge, `cur_addr` equals `addr_byte` after that edge.
- R6: With `byte_mode`=0 and `bank_split`=0, each advance adds one to the pointer, and an advance from 15h or above gives 00h.
- R7: With `byte_mode`=0 and `bank_split`=1, an advance from 0Ah gives 10h, and an advance from 1Ah or above gives 00h. Every other advance adds one.
- R8: With `byte_mode`=1 and `bank_split`=0, an advance from a valid address inverts address bit 0, and an advance from an invalid address leaves the pointer unchanged.
- R9: With `byte_mode`=1 and `bank_split`=1, an advance leaves the pointer unchanged.
- R10: If `addr_load` and `byte_done` are both 1 at the same edge, the loaded byte is taken and the advance is dropped.
- R11: With neither `addr_load` nor `byte_done` active, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_load | input | 1 | Load strobe for a new register address |
| addr_byte | input | ADDR_W | Register address from the serial front end |
| byte_done | input | 1 | Advance strobe, one pulse per completed data byte |
| bank_split | input | 1 | Map select: 0 interleaved, 1 split |
| byte_mode | input | 1 | 1 = byte mode (hold or toggle), 0 = sequential |
| cur_addr | output | ADDR_W | Current pointer value |
| reg_pair | output | $clog2(NUM_PAIRS) | Decoded pair number |
| reg_port_b | output | 1 | Decoded port select, 1 = port B |
| reg_valid | output | 1 | Pointer hits a mapped register |
| cfg_hit | output | 1 | Pointer hits the shared configuration register |

## Verification
The bench goes after each seam of the maps.

In the split map it steps across the jump from 0Ah to 10h and across the wrap after 1Ah. A design that only added one at each advance would walk into the gap at 0Bh, which decodes as invalid, and the pair and port outputs would disagree with the model.

It runs the interleaved wrap at 15h. It also runs byte-mode toggling from both the A and the B address of a pair, and from an invalid address. A toggle on the wrong bit, or a toggle out of the mapped range, shows up as a wrong pointer.

It loads each alias of the configuration register. A decoder that reported the configuration register as port B at its odd alias would fail the port check.

It drives a load and an advance in the same cycle to expose a wrong priority between the two.

// File: rtl/bptr_pkg.sv
package bptr_pkg;
  typedef enum logic [1:0] {
    ADV_NONE   = 2'd0,
    ADV_INC    = 2'd1,
    ADV_HOLD   = 2'd2,
    ADV_TOGGLE = 2'd3
  } adv_kind_e;
endpackage

// File: rtl/bptr_decode.sv
module bptr_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_PAIRS = 11,
  parameter int B_BASE    = 16,
  parameter int CFG_PAIR  = 5
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         split,
  output logic                         valid,
  output logic [$clog2(NUM_PAIRS)-1:0] pair,
  output logic                         port_b,
  output logic                         cfg
);
  localparam int PAIR_W  = $clog2(NUM_PAIRS);
  localparam int LAST_IL = 2 * NUM_PAIRS - 1;
  localparam int LAST_A  = NUM_PAIRS - 1;
  localparam int LAST_B  = B_BASE + NUM_PAIRS - 1;

  logic              raw_valid;
  logic [PAIR_W-1:0] raw_pair;
  logic              raw_b;

  always_comb begin
    raw_valid = 1'b0;
    raw_pair  = '0;
    raw_b     = 1'b0;
    if (!split) begin
      if (addr <= ADDR_W'(LAST_IL)) begin
        raw_valid = 1'b1;
        raw_pair  = PAIR_W'(addr >> 1);
        raw_b     = addr[0];
      end
    end else begin
      if (addr <= ADDR_W'(LAST_A)) begin
        raw_valid = 1'b1;
        raw_pair  = PAIR_W'(addr);
      end else if (addr >= ADDR_W'(B_BASE) && addr <= ADDR_W'(LAST_B)) begin
        raw_valid = 1'b1;
        raw_pair  = PAIR_W'(addr - ADDR_W'(B_BASE));
        raw_b     = 1'b1;
      end
    end
  end

  // The shared configuration register exists once; both aliases select port A.
  always_comb begin
    valid  = raw_valid;
    pair   = raw_pair;
    cfg    = raw_valid && (raw_pair == PAIR_W'(CFG_PAIR));
    port_b = raw_b && !cfg;
  end
endmodule

// File: rtl/bptr_step.sv
module bptr_step
  import bptr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PAIRS = 11,
  parameter int B_BASE    = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              split,
  input  adv_kind_e         kind,
  output logic [ADDR_W-1:0] nxt
);
  localparam int LAST_IL = 2 * NUM_PAIRS - 1;
  localparam int LAST_A  = NUM_PAIRS - 1;
  localparam int LAST_B  = B_BASE + NUM_PAIRS - 1;

  function automatic logic [ADDR_W-1:0] inc_addr(input logic [ADDR_W-1:0] a,
                                                 input logic s);
    logic [ADDR_W-1:0] r;
    if (!s) begin
      r = (a >= ADDR_W'(LAST_IL)) ? '0 : a + ADDR_W'(1);
    end else if (a == ADDR_W'(LAST_A)) begin
      r = ADDR_W'(B_BASE);
    end else if (a >= ADDR_W'(LAST_B)) begin
      r = '0;
    end else begin
      r = a + ADDR_W'(1);
    end
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] partner(input logic [ADDR_W-1:0] a);
    return a ^ ADDR_W'(1);
  endfunction

  always_comb begin
    unique case (kind)
      ADV_INC:    nxt = inc_addr(addr, split);
      ADV_TOGGLE: nxt = partner(addr);
      default:    nxt = addr;
    endcase
  end
endmodule

// File: rtl/bank_addr_ptr.sv
module bank_addr_ptr
  import bptr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PAIRS = 11,
  parameter int B_BASE    = 16,
  parameter int CFG_PAIR  = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         addr_load,
  input  logic [ADDR_W-1:0]            addr_byte,
  input  logic                         byte_done,
  input  logic                         bank_split,
  input  logic                         byte_mode,
  output logic [ADDR_W-1:0]            cur_addr,
  output logic [$clog2(NUM_PAIRS)-1:0] reg_pair,
  output logic                         reg_port_b,
  output logic                         reg_valid,
  output logic                         cfg_hit
);
  localparam int LAST_IL = 2 * NUM_PAIRS - 1;

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] step_addr;
  logic              do_load;
  logic              do_adv;
  logic              in_il_range;
  adv_kind_e         step_kind;

  assign do_load     = addr_load;
  assign do_adv      = byte_done && !addr_load;
  assign in_il_range = ptr_q <= ADDR_W'(LAST_IL);

  always_comb begin
    if (!do_adv)                         step_kind = ADV_NONE;
    else if (!byte_mode)                 step_kind = ADV_INC;
    else if (bank_split || !in_il_range) step_kind = ADV_HOLD;
    else                                 step_kind = ADV_TOGGLE;
  end

  bptr_step #(
    .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .B_BASE(B_BASE)
  ) u_step (
    .addr (ptr_q),
    .split(bank_split),
    .kind (step_kind),
    .nxt  (step_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (do_load) ptr_q <= addr_byte;
    else              ptr_q <= step_addr;
  end

  bptr_decode #(
    .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .B_BASE(B_BASE), .CFG_PAIR(CFG_PAIR)
  ) u_dec (
    .addr  (ptr_q),
    .split (bank_split),
    .valid (reg_valid),
    .pair  (reg_pair),
    .port_b(reg_port_b),
    .cfg   (cfg_hit)
  );

  assign cur_addr = ptr_q;
endmodule

// File: rtl/bank_addr_ptr_chk.sv
module bank_addr_ptr_chk
  import bptr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PAIRS = 11,
  parameter int B_BASE    = 16,
  parameter int CFG_PAIR  = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         addr_load,
  input logic [ADDR_W-1:0]            addr_byte,
  input logic                         byte_done,
  input logic                         bank_split,
  input logic                         byte_mode,
  input logic [ADDR_W-1:0]            cur_addr,
  input logic [$clog2(NUM_PAIRS)-1:0] reg_pair,
  input logic                         reg_port_b,
  input logic                         reg_valid,
  input logic                         cfg_hit,
  input adv_kind_e                    step_kind
);
  localparam int LAST_IL = 2 * NUM_PAIRS - 1;
  localparam int LAST_A  = NUM_PAIRS - 1;

  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> cur_addr == $past(addr_byte)); // R5

  AST_LOAD_OVER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && byte_done) |-> step_kind == ADV_NONE); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && !byte_done) |=> $stable(cur_addr)); // R11

  AST_SPLIT_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && byte_done && byte_mode && bank_split) |=> $stable(cur_addr)); // R9

  AST_IL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && byte_done && byte_mode && !bank_split &&
     cur_addr <= ADDR_W'(LAST_IL)) |=> cur_addr == ($past(cur_addr) ^ ADDR_W'(1))); // R8

  AST_IL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && byte_done && !byte_mode && !bank_split &&
     cur_addr == ADDR_W'(LAST_IL)) |=> cur_addr == '0); // R6

  AST_SPLIT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && byte_done && !byte_mode && bank_split &&
     cur_addr == ADDR_W'(LAST_A)) |=> cur_addr == ADDR_W'(B_BASE)); // R7

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |-> (reg_pair == '0 && !reg_port_b && !cfg_hit)); // R3

  AST_CFG_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |-> (reg_valid && !reg_port_b &&
                 int'(reg_pair) == CFG_PAIR)); // R4
endmodule

bind bank_addr_ptr bank_addr_ptr_chk #(
  .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .B_BASE(B_BASE), .CFG_PAIR(CFG_PAIR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_byte(addr_byte),
  .byte_done(byte_done), .bank_split(bank_split), .byte_mode(byte_mode),
  .cur_addr(cur_addr), .reg_pair(reg_pair), .reg_port_b(reg_port_b),
  .reg_valid(reg_valid), .cfg_hit(cfg_hit), .step_kind(step_kind)
);

// File: tb/tb_bank_addr_ptr.sv
`timescale 1ns/1ps
module tb_bank_addr_ptr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld = 1'b0;
  logic [7:0] la = 8'd0;
  logic       adv = 1'b0;
  logic       bank = 1'b0;
  logic       bm = 1'b0;
  logic [7:0] o_addr;
  logic [3:0] o_pair;
  logic       o_b, o_v, o_cfg;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    m_ptr = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  bank_addr_ptr dut (
    .clk(clk), .rst_n(rst_n), .addr_load(ld), .addr_byte(la),
    .byte_done(adv), .bank_split(bank), .byte_mode(bm),
    .cur_addr(o_addr), .reg_pair(o_pair), .reg_port_b(o_b),
    .reg_valid(o_v), .cfg_hit(o_cfg)
  );

  function automatic int model_next(int p, bit s, bit byt);
    if (byt) begin
      if (s) return p;
      if (p < 22) return (p % 2 == 0) ? p + 1 : p - 1;
      return p;
    end
    if (!s) return (p >= 21) ? 0 : p + 1;
    if (p == 10) return 16;
    if (p >= 26) return 0;
    return p + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)   m_ptr <= 0;
    else if (ld)  m_ptr <= int'(la);
    else if (adv) m_ptr <= model_next(m_ptr, bank, bm);
  end

  task automatic check();
    int ev, ep, eb, ec;
    ev = 0; ep = 0; eb = 0; ec = 0;
    if (!bank) begin
      if (m_ptr < 22) begin ev = 1; ep = m_ptr / 2; eb = m_ptr % 2; end
    end else begin
      if (m_ptr < 11) begin ev = 1; ep = m_ptr; end
      else if (m_ptr >= 16 && m_ptr < 27) begin ev = 1; ep = m_ptr - 16; eb = 1; end
    end
    if (ev == 1 && ep == 5) begin ec = 1; eb = 0; end
    n_cmp++;
    if (int'(o_addr) != m_ptr || int'(o_pair) != ep || int'(o_b) != eb ||
        int'(o_v) != ev || int'(o_cfg) != ec) begin
      n_bad++;
      $display("FAIL %s: actual addr=%0h pair=%0d b=%0d v=%0d cfg=%0d expected addr=%0h pair=%0d b=%0d v=%0d cfg=%0d",
               cur_req, o_addr, o_pair, o_b, o_v, o_cfg, m_ptr, ep, eb, ev, ec);
    end
  endtask

  task automatic cyc(input bit l, input int a, input bit d);
    ld = l; la = 8'(a); adv = d;
    @(posedge clk);
    @(negedge clk);
    check();
    ld = 1'b0; adv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1"; check();
    rst_n = 1'b1;
    cyc(0, 0, 0);
    // R2 / R5: interleaved map loads
    cur_req = "R2";
    for (int a = 0; a < 24; a++) cyc(1, a, 0);
    // R3: split map, including gaps
    bank = 1'b1; cur_req = "R3";
    for (int a = 0; a < 32; a++) cyc(1, a, 0);
    cyc(1, 200, 0);
    // R4: configuration aliases
    cur_req = "R4";
    cyc(1, 5, 0); cyc(1, 21, 0);
    bank = 1'b0;
    cyc(1, 10, 0); cyc(1, 11, 0);
    // R5: arbitrary load values
    cur_req = "R5";
    cyc(1, 255, 0); cyc(1, 7, 0);
    // R6: sequential, interleaved wrap
    cur_req = "R6";
    cyc(1, 19, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1);
    cyc(1, 40, 0); cyc(0, 0, 1);
    // R7: sequential, split map jump and wrap
    bank = 1'b1; cur_req = "R7";
    cyc(1, 9, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    cyc(1, 25, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    cyc(1, 12, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1);
    // R8: byte mode toggle, interleaved map
    bank = 1'b0; bm = 1'b1; cur_req = "R8";
    cyc(1, 18, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    cyc(1, 19, 0); cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(1, 30, 0); cyc(0, 0, 1); cyc(0, 0, 1);
    // R9: byte mode hold, split map
    bank = 1'b1; cur_req = "R9";
    cyc(1, 20, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    // R10: load wins over advance
    cur_req = "R10";
    cyc(1, 3, 1);
    bm = 1'b0;
    cyc(1, 10, 1); cyc(0, 0, 1);
    // R11: idle holds
    cur_req = "R11";
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule